// File: doc/BRIEF.md
# Millisecond Watchdog Timer with Pulse Output

This block is a free-running timeout timer. Its period is held in a 16-bit register counted in milliseconds; a value of zero turns the timer off. While the period is nonzero, a prescaler turns the system clock into a millisecond tick. A millisecond counter then counts those ticks, fires when the programmed period has elapsed and starts over by itself.

Each expiry is reported twice. The first is a single-cycle flag meant for an interrupt collector. The second is a pin pulse stretched to a fixed 32 system clocks. Software can push the deadline back by strobing a self-clearing restart bit. A hardware pin can do the same when its enable is set. Writing the period also restarts the count. The prescale ratio is a parameter, so a bench can use a short millisecond.

Top module: `ms_watchdog`

## Requirements
- R1: The period register is 16 bits wide and counts milliseconds. After a write of a nonzero value P, the first expiry flag is high in the cycle that follows exactly P*CLKS_PER_MS rising edges, counting the write edge as edge zero.
- R2: While the period register holds 0, neither the expiry flag nor the pulse output is ever asserted.
- R3: With a nonzero period, expiries repeat every P*CLKS_PER_MS cycles with no further stimulus.
- R4: `wd_expire_irq` is high for one cycle per expiry, and it is high in the first cycle of each pin pulse.
- R5: The pin output `wd_pulse` stays high for exactly 32 consecutive cycles after an isolated expiry.
- R6: A one-cycle strobe on `restart_strobe` clears the count, so the next expiry comes P*CLKS_PER_MS cycles after the strobe edge.
- R7: When `restart_pin_en` is 1, a high `restart_pin` restarts the count in the same way as R6. When the enable is 0, the pin has no effect.
- R8: Writing a nonzero period restarts the count from zero, even while the timer is already running.
- R9: Writing 0 stops the timer at once. Any pulse in progress is cleared, so `wd_pulse` is low in the cycle after the write edge.
- R10: If a restart lands on the same edge as an expiry, the restart wins and no flag or pulse is produced. The next expiry comes a full period later.
- R11: If a new expiry comes while a pulse is active, the 32-cycle pulse starts over. With periods shorter than 32 cycles, the pin therefore stays high continuously.
- R12: After reset the period is 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_wr | input | 1 | One-cycle write strobe for the period register |
| period_wdata | input | 16 | New period in milliseconds; 0 disables |
| restart_strobe | input | 1 | Self-clearing restart bit, high for one cycle per write |
| restart_pin | input | 1 | Hardware restart input, synchronous to clk |
| restart_pin_en | input | 1 | 1 lets restart_pin restart the timer |
| wd_expire_irq | output | 1 | One-cycle expiry flag for the interrupt collector |
| wd_pulse | output | 1 | Expiry pulse stretched to 32 clocks |

## Verification
The hardest case to reach from the ports is a restart that falls on the exact edge where the period would expire. The stimulus writes a period and counts edges from the write edge. It then raises the restart strobe so that the strobe is sampled on edge P*CLKS_PER_MS exactly. It checks that no flag or pulse appears there and that the next expiry is a full period later. Retriggering the pulse is reached by programming a 1 ms period with a four-clock millisecond, so expiries come faster than the pulse can end.

// File: rtl/wd_pkg.sv
package wd_pkg;

    localparam int WD_PERIOD_W = 16;
    localparam int WD_PULSE_LEN = 32;

    typedef logic [WD_PERIOD_W-1:0] wd_period_t;

    // control decoded from the block's inputs for one cycle
    typedef struct packed {
        logic       load;     // period register written
        logic       restart;  // bit or pin restart
        wd_period_t value;    // data presented with the write
    } wd_ctrl_t;

    typedef enum logic [1:0] {
        WD_OFF     = 2'b00,
        WD_RUNNING = 2'b01,
        WD_CLEARED = 2'b10
    } wd_state_e;

    function automatic logic wd_period_live(input wd_period_t p);
        return p != '0;
    endfunction

    function automatic logic wd_stop_write(input wd_ctrl_t c);
        return c.load && !wd_period_live(c.value);
    endfunction

endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    generate
        if (DIV == 1) begin : g_passthru
            assign tick = run && !clear;
            always_ff @(posedge clk) begin
                cnt_q <= '0;
            end
        end else begin : g_divide
            assign tick = run && !clear && (cnt_q == LAST);
            always_ff @(posedge clk) begin
                if (rst || clear || !run) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wd_ms_counter.sv
module wd_ms_counter
    import wd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       clear,
    input  wd_period_t period,
    output logic       expire
);
    wd_period_t ms_q;
    wd_period_t last_ms;

    assign last_ms = period - 1'b1;
    assign expire  = tick && !clear && wd_period_live(period) && (ms_q == last_ms);

    always_ff @(posedge clk) begin
        if (rst || clear || !wd_period_live(period)) begin
            ms_q <= '0;
        end else if (expire) begin
            ms_q <= '0;
        end else if (tick) begin
            ms_q <= ms_q + 1'b1;
        end
    end
endmodule

// File: rtl/wd_pulse_stretch.sv
module wd_pulse_stretch #(
    parameter int LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic kill,
    output logic pulse
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse = (left_q != '0);
endmodule

// File: rtl/ms_watchdog.sv
module ms_watchdog
    import wd_pkg::*;
#(
    parameter int CLKS_PER_MS = 100000,
    parameter int PULSE_LEN   = WD_PULSE_LEN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   period_wr,
    input  logic [WD_PERIOD_W-1:0] period_wdata,
    input  logic                   restart_strobe,
    input  logic                   restart_pin,
    input  logic                   restart_pin_en,
    output logic                   wd_expire_irq,
    output logic                   wd_pulse
);
    wd_ctrl_t   ctrl;
    wd_period_t period_q;
    wd_state_e  state;
    logic       tick;
    logic       expire;
    logic       clear_cnt;
    logic       irq_q;

    always_comb begin
        ctrl.load    = period_wr;
        ctrl.restart = restart_strobe || (restart_pin && restart_pin_en);
        ctrl.value   = period_wdata;
    end

    assign clear_cnt = ctrl.load || ctrl.restart;

    always_comb begin
        if (!wd_period_live(period_q)) begin
            state = WD_OFF;
        end else if (clear_cnt) begin
            state = WD_CLEARED;
        end else begin
            state = WD_RUNNING;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
        end else if (ctrl.load) begin
            period_q <= ctrl.value;
        end
    end

    wd_prescaler #(.DIV(CLKS_PER_MS)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (state != WD_OFF),
        .clear (clear_cnt),
        .tick  (tick)
    );

    wd_ms_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .clear  (clear_cnt),
        .period (period_q),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire && (state == WD_RUNNING);
        end
    end

    wd_pulse_stretch #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (expire && (state == WD_RUNNING)),
        .kill  (wd_stop_write(ctrl)),
        .pulse (wd_pulse)
    );

    assign wd_expire_irq = irq_q;
endmodule

// File: rtl/ms_watchdog_checker.sv
module ms_watchdog_checker
    import wd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       period_wr,
    input wd_period_t period_wdata,
    input logic       restart_strobe,
    input logic       restart_pin,
    input logic       restart_pin_en,
    input wd_period_t period_q,
    input logic       wd_expire_irq,
    input logic       wd_pulse
);
    assert_irq_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        wd_expire_irq |-> wd_pulse);

    assert_pulse_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_pulse) |-> wd_expire_irq);

    assert_bit_restart_R10: assert property (@(posedge clk) disable iff (rst)
        restart_strobe |=> !wd_expire_irq);

    assert_pin_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (restart_pin && restart_pin_en) |=> !wd_expire_irq);

    assert_zero_write_R9: assert property (@(posedge clk) disable iff (rst)
        (period_wr && period_wdata == '0) |=> (!wd_pulse && !wd_expire_irq));

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (period_q == '0 && !period_wr) |=> !wd_expire_irq);
endmodule

bind ms_watchdog ms_watchdog_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .period_wr      (period_wr),
    .period_wdata   (period_wdata),
    .restart_strobe (restart_strobe),
    .restart_pin    (restart_pin),
    .restart_pin_en (restart_pin_en),
    .period_q       (period_q),
    .wd_expire_irq  (wd_expire_irq),
    .wd_pulse       (wd_pulse)
);

// File: tb/sim_ms_watchdog.sv
`timescale 1ns/1ps
module sim_ms_watchdog;
    localparam int DIV = 4;
    localparam int PLEN = 32;

    // period in ms, expected cycles to first expiry
    localparam int VEC [4][2] = '{'{9, 36}, '{12, 48}, '{20, 80}, '{50, 200}};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        period_wr = 1'b0;
    logic [15:0] period_wdata = '0;
    logic        restart_strobe = 1'b0;
    logic        restart_pin = 1'b0;
    logic        restart_pin_en = 1'b0;
    logic        wd_expire_irq;
    logic        wd_pulse;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ms_watchdog #(.CLKS_PER_MS(DIV), .PULSE_LEN(PLEN)) u0 (
        .clk            (clk),
        .rst            (rst),
        .period_wr      (period_wr),
        .period_wdata   (period_wdata),
        .restart_strobe (restart_strobe),
        .restart_pin    (restart_pin),
        .restart_pin_en (restart_pin_en),
        .wd_expire_irq  (wd_expire_irq),
        .wd_pulse       (wd_pulse)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_period(input int v);
        period_wr = 1'b1;
        period_wdata = 16'(v);
        step();
        period_wr = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output int k);
        k = 0;
        do begin
            step();
            k++;
        end while (!wd_expire_irq && k < limit);
        if (!wd_expire_irq) k = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int k;
        int n;
        int seen;
        repeat (3) step();
        rst = 1'b0;

        // R12 reset state
        check("R12 irq after reset", wd_expire_irq, 0);
        check("R12 pulse after reset", wd_pulse, 0);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            seen += wd_expire_irq + wd_pulse;
        end
        check("R12 reset period is zero, no activity", seen, 0);

        // table walk: R1 first expiry, R5 width, R3 repeat
        for (int v = 0; v < 4; v++) begin
            wr_period(VEC[v][0]);
            wait_irq(1000, k);
            check("R1 first expiry cycles", k, VEC[v][1]);
            check("R4 pulse high with flag", wd_pulse, 1);
            n = 1;
            step();
            check("R4 flag lasts one cycle", wd_expire_irq, 0);
            while (wd_pulse && n < 100) begin
                n++;
                step();
            end
            check("R5 pulse width", n, PLEN);
            wait_irq(1000, k);
            check("R3 repeat interval", k + n, VEC[v][1]);
        end

        // R8 rewrite while running restarts
        wr_period(10);
        repeat (25) step();
        wr_period(10);
        wait_irq(1000, k);
        check("R8 rewrite restarts count", k, 40);

        // R6 restart bit
        wr_period(10);
        repeat (30) step();
        restart_strobe = 1'b1;
        step();
        restart_strobe = 1'b0;
        wait_irq(1000, k);
        check("R6 restart bit delays expiry", k, 40);

        // R7 pin disabled: no effect
        wr_period(10);
        repeat (20) step();
        restart_pin = 1'b1;
        restart_pin_en = 1'b0;
        step();
        restart_pin = 1'b0;
        wait_irq(1000, k);
        check("R7 pin ignored when disabled", k, 19);

        // R7 pin enabled
        wr_period(10);
        repeat (20) step();
        restart_pin = 1'b1;
        restart_pin_en = 1'b1;
        step();
        restart_pin = 1'b0;
        restart_pin_en = 1'b0;
        wait_irq(1000, k);
        check("R7 pin restart when enabled", k, 40);

        // R10 restart on the expiry edge
        wr_period(0);
        step();
        wr_period(10);
        repeat (39) step();
        restart_strobe = 1'b1;
        step();
        restart_strobe = 1'b0;
        check("R10 no flag on collided edge", wd_expire_irq, 0);
        check("R10 no pulse on collided edge", wd_pulse, 0);
        wait_irq(1000, k);
        check("R10 next expiry a full period later", k, 40);

        // R9 zero write clears pulse in progress, then R2 silence
        wr_period(9);
        wait_irq(1000, k);
        repeat (5) step();
        wr_period(0);
        check("R9 pulse cleared by zero write", wd_pulse, 0);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            seen += wd_expire_irq + wd_pulse;
        end
        check("R2 disabled timer stays quiet", seen, 0);

        // R11 retrigger: 1 ms period = 4 cycles
        wr_period(1);
        wait_irq(100, k);
        check("R11 fast first expiry", k, 4);
        seen = 0;
        n = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            seen += wd_expire_irq;
            n += wd_pulse;
        end
        check("R11 pulse held continuously", n, 60);
        check("R11 flags every period", seen, 15);
        wr_period(0);
        check("R9 stop clears retriggered pulse", wd_pulse, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule